// File: doc/BRIEF.md
# Oversampled Manchester Word Receiver

This block turns the serial biphase stream of a 1 Mb/s command/response bus into parallel words. The analog receiver delivers the line as a pair of complementary levels. The block samples the pair at sixteen times the bit rate. While both wires are low the bus is idle. When exactly one wire is high the bus is active, and the positive wire carries the level.

The first active sample starts a 48-sample window that covers the three-bit-time sync pattern. The sync is accepted when each half of the window holds enough samples of its expected level; a couple of samples lost to slow edges are tolerated. The level that leads the pattern gives the word its kind. After the sync, the receiver reads each of the 17 following bits from the two samples around the bit centre. It checks the parity and then presents a 20-bit word with a one-cycle strobe.

A broken pattern ends the word with an error pulse. After any result the receiver stays deaf until the line has gone idle.

Top module: `mwd_decoder`

## Requirements
- R1: After reset every output is 0, and while the line stays idle (both wires low) no strobe or error pulse is produced.
- R2: A sync that is high for the first 1.5 bit times and low for the next 1.5 (a command or status word) yields word bits [19:17] = 3'b011 and `word_cmd_o` = 1.
- R3: A sync that is low first and then high (a data word) yields word bits [19:17] = 3'b100 and `word_cmd_o` = 0.
- R4: The sync window is 48 samples long, counted from the first active sample. The sync is accepted when at least 22 of the first 24 samples carry the leading level and at least 22 of the last 24 carry the opposite level. Otherwise `sync_err_o` pulses and no word is delivered.
- R5: Each bit is decided from the samples at offsets 7 and 8 of its 16-sample cell: high then low decodes to 1, and low then high decodes to 0. The first data bit received lands in word bit 16 and the parity bit in word bit 0.
- R6: When the two centre samples of any data or parity bit are equal, `trans_err_o` pulses for one cycle, the word is dropped and no strobe is given.
- R7: The parity is odd over the 16 data bits plus the parity bit. With an even count of ones, `par_err_o` is 1 in the same cycle as `word_valid_o`, and the word is still delivered.
- R8: `word_valid_o` is a single-cycle pulse per word. `word_o` and `word_cmd_o` hold their values until the next strobe, including across failed words.
- R9: After a strobe or an error, line activity is ignored until at least one idle sample has been seen. A word that follows with no idle gap is therefore not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pos_i | input | 1 | Positive receiver output; carries the line level |
| rx_neg_i | input | 1 | Negative receiver output; both low means idle |
| word_o | output | DATA_W+4 | {sync code[2:0], data, parity} of the last good word |
| word_valid_o | output | 1 | One-cycle strobe: new word on `word_o` |
| word_cmd_o | output | 1 | 1 for a command/status word, 0 for a data word |
| par_err_o | output | 1 | Parity failure, qualified by `word_valid_o` |
| trans_err_o | output | 1 | Pulse: missing mid-bit transition |
| sync_err_o | output | 1 | Pulse: sync pattern out of tolerance |

## Verification
The checker watches, on every cycle, that at most one of strobe, transition error and sync error fires at a time. It also checks that the strobe is one cycle wide, that the word holds between strobes, that the parity flag only appears with a strobe, that each strobe carries a legal sync code matching the word-kind flag, and that no result comes out of a long idle stretch. The tolerance limits of the sync window, the value of every decoded bit and its placement, the parity verdict, and the refusal to decode a word that follows with no idle gap can only be shown by the bench. It does this by driving sample-exact waveforms and comparing the results against words it builds arithmetically.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SYNC,
      ST_BITS,
      ST_HOLD
   } mwd_state_e;

   localparam logic [2:0] SYNC_CODE_CMD  = 3'b011;
   localparam logic [2:0] SYNC_CODE_DATA = 3'b100;

   function automatic logic [2:0] sync_code(input logic is_cmd);
      return is_cmd ? SYNC_CODE_CMD : SYNC_CODE_DATA;
   endfunction

endpackage

// File: rtl/mwd_line_front.sv
// Registers the receiver pair through a configurable flop chain and derives
// the line level and the active (not idle) indication.
module mwd_line_front #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pos_i,
   input  logic neg_i,
   output logic level_o,
   output logic active_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("mwd_line_front: STAGES must be at least 1");
   end

   logic pos_q;
   logic neg_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pos_q <= 1'b0;
            neg_q <= 1'b0;
         end else begin
            pos_q <= pos_i;
            neg_q <= neg_i;
         end
      end
   end else begin : g_chain
      logic [STAGES-1:0] pos_sr;
      logic [STAGES-1:0] neg_sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pos_sr <= '0;
            neg_sr <= '0;
         end else begin
            pos_sr <= {pos_sr[STAGES-2:0], pos_i};
            neg_sr <= {neg_sr[STAGES-2:0], neg_i};
         end
      end
      assign pos_q = pos_sr[STAGES-1];
      assign neg_q = neg_sr[STAGES-1];
   end

   assign level_o  = pos_q;
   assign active_o = pos_q ^ neg_q;

endmodule

// File: rtl/mwd_sync_qual.sv
// Counts samples over the three-bit-time sync window and judges them
// against the tolerance. Its verdict is combinational in the last sample.
module mwd_sync_qual #(
   parameter int OSR = 16,
   parameter int TOL = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic level_i,
   output logic last_o,
   output logic ok_o,
   output logic lead_o
);

   localparam int HALF = (3 * OSR) / 2;
   localparam int SPAN = 2 * HALF;
   localparam int IW   = $clog2(SPAN);
   localparam int HW   = $clog2(HALF + 1);
   localparam int MINC = HALF - TOL;

   localparam logic [IW-1:0] HALF_I = IW'(HALF);
   localparam logic [IW-1:0] LAST_I = IW'(SPAN - 1);
   localparam logic [HW-1:0] MIN_H  = HW'(MINC);

   logic [IW-1:0] idx_q;
   logic [HW-1:0] hits_a_q;
   logic [HW-1:0] hits_b_q;
   logic [HW-1:0] hits_b_nx;
   logic          lead_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         hits_a_q <= '0;
         hits_b_q <= '0;
         lead_q   <= 1'b0;
         busy_q   <= 1'b0;
      end else if (start_i) begin
         lead_q   <= level_i;
         idx_q    <= IW'(1);
         hits_a_q <= HW'(1);
         hits_b_q <= '0;
         busy_q   <= 1'b1;
      end else if (busy_q) begin
         idx_q <= idx_q + IW'(1);
         if (idx_q < HALF_I) begin
            hits_a_q <= hits_a_q + HW'(level_i == lead_q);
         end else begin
            hits_b_q <= hits_b_nx;
         end
         if (idx_q == LAST_I) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign hits_b_nx = hits_b_q + HW'(level_i != lead_q);
   assign last_o    = busy_q && (idx_q == LAST_I);
   assign ok_o      = (hits_a_q >= MIN_H) && (hits_b_nx >= MIN_H);
   assign lead_o    = lead_q;

endmodule

// File: rtl/mwd_bit_slicer.sv
// Walks the sample cells of the bit field and decides each bit from the
// two samples that straddle the cell centre.
module mwd_bit_slicer #(
   parameter int OSR = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic level_i,
   output logic stb_o,
   output logic bit_o,
   output logic flat_o
);

   localparam int PW = $clog2(OSR);
   localparam logic [PW-1:0] MID_I  = PW'(OSR / 2);
   localparam logic [PW-1:0] PRE_I  = PW'(OSR / 2 - 1);
   localparam logic [PW-1:0] LAST_I = PW'(OSR - 1);

   logic [PW-1:0] phase_q;
   logic          early_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         early_q <= 1'b0;
      end else if (!en_i) begin
         phase_q <= '0;
      end else begin
         phase_q <= (phase_q == LAST_I) ? '0 : phase_q + PW'(1);
         if (phase_q == PRE_I) begin
            early_q <= level_i;
         end
      end
   end

   assign stb_o  = en_i && (phase_q == MID_I);
   assign bit_o  = early_q;
   assign flat_o = (early_q == level_i);

endmodule

// File: rtl/mwd_decoder.sv
module mwd_decoder #(
   parameter int OSR         = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_TOL    = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit ODD_PARITY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_pos_i,
   input  logic              rx_neg_i,
   output logic [DATA_W+3:0] word_o,
   output logic              word_valid_o,
   output logic              word_cmd_o,
   output logic              par_err_o,
   output logic              trans_err_o,
   output logic              sync_err_o
);
   import mwd_pkg::*;

   localparam int PAY_W = DATA_W + 1;
   localparam int NW    = $clog2(PAY_W + 1);
   localparam logic [NW-1:0] NB_LAST = NW'(DATA_W);

   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("mwd_decoder: OSR must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("mwd_decoder: DATA_W must be at least 2");
   end
   if (SYNC_TOL < 0 || SYNC_TOL >= (3 * OSR) / 2) begin : g_bad_tol
      $error("mwd_decoder: SYNC_TOL out of range");
   end

   logic line_lvl;
   logic line_act;

   mwd_line_front #(.STAGES(SYNC_STAGES)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .pos_i    (rx_pos_i),
      .neg_i    (rx_neg_i),
      .level_o  (line_lvl),
      .active_o (line_act)
   );

   mwd_state_e state_q;

   logic sync_start;
   logic sync_last;
   logic sync_ok;
   logic sync_lead;

   assign sync_start = (state_q == ST_IDLE) && line_act;

   mwd_sync_qual #(.OSR(OSR), .TOL(SYNC_TOL)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (sync_start),
      .level_i (line_lvl),
      .last_o  (sync_last),
      .ok_o    (sync_ok),
      .lead_o  (sync_lead)
   );

   logic bit_stb;
   logic bit_val;
   logic bit_flat;

   mwd_bit_slicer #(.OSR(OSR)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (state_q == ST_BITS),
      .level_i (line_lvl),
      .stb_o   (bit_stb),
      .bit_o   (bit_val),
      .flat_o  (bit_flat)
   );

   logic [DATA_W-1:0] acc_q;
   logic [NW-1:0]     nbit_q;
   logic [PAY_W-1:0]  payload;
   logic              par_bad;

   assign payload = {acc_q, bit_val};

   if (ODD_PARITY) begin : g_odd
      assign par_bad = ~(^payload);
   end else begin : g_even
      assign par_bad = ^payload;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         acc_q        <= '0;
         nbit_q       <= '0;
         word_o       <= '0;
         word_valid_o <= 1'b0;
         word_cmd_o   <= 1'b0;
         par_err_o    <= 1'b0;
         trans_err_o  <= 1'b0;
         sync_err_o   <= 1'b0;
      end else begin
         word_valid_o <= 1'b0;
         par_err_o    <= 1'b0;
         trans_err_o  <= 1'b0;
         sync_err_o   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (line_act) begin
                  state_q <= ST_SYNC;
               end
            end
            ST_SYNC: begin
               if (sync_last) begin
                  nbit_q <= '0;
                  if (sync_ok) begin
                     state_q <= ST_BITS;
                  end else begin
                     sync_err_o <= 1'b1;
                     state_q    <= ST_HOLD;
                  end
               end
            end
            ST_BITS: begin
               if (bit_stb) begin
                  if (bit_flat) begin
                     trans_err_o <= 1'b1;
                     state_q     <= ST_HOLD;
                  end else if (nbit_q == NB_LAST) begin
                     word_o       <= {sync_code(sync_lead), payload};
                     word_cmd_o   <= sync_lead;
                     word_valid_o <= 1'b1;
                     par_err_o    <= par_bad;
                     state_q      <= ST_HOLD;
                  end else begin
                     acc_q  <= {acc_q[DATA_W-2:0], bit_val};
                     nbit_q <= nbit_q + NW'(1);
                  end
               end
            end
            ST_HOLD: begin
               if (!line_act) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mwd_decoder_chk.sv
module mwd_decoder_chk #(
   parameter int OSR         = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_pos_i,
   input logic              rx_neg_i,
   input logic [DATA_W+3:0] word_o,
   input logic              word_valid_o,
   input logic              word_cmd_o,
   input logic              par_err_o,
   input logic              trans_err_o,
   input logic              sync_err_o
);

   localparam int LIMIT = 4 * OSR + SYNC_STAGES + 4;
   localparam int QW    = $clog2(LIMIT + 2);
   localparam logic [QW-1:0] Q_LIMIT = QW'(LIMIT);
   localparam logic [QW-1:0] Q_MAX   = QW'(LIMIT + 1);

   logic [QW-1:0] quiet_q;
   logic          any_evt;

   assign any_evt = word_valid_o || trans_err_o || sync_err_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= Q_MAX;
      end else if (rx_pos_i != rx_neg_i) begin
         quiet_q <= '0;
      end else if (quiet_q != Q_MAX) begin
         quiet_q <= quiet_q + QW'(1);
      end
   end

   AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |-> (quiet_q < Q_LIMIT)); // R1
   AST_TYPE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> ((word_o[DATA_W+3:DATA_W+1] == 3'b011) && word_cmd_o) ||
                       ((word_o[DATA_W+3:DATA_W+1] == 3'b100) && !word_cmd_o)); // R2
   AST_DATA_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && !word_cmd_o) |-> (word_o[DATA_W+3:DATA_W+1] == 3'b100)); // R3
   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({word_valid_o, trans_err_o, sync_err_o})); // R6
   AST_PAR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      par_err_o |-> word_valid_o); // R7
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |=> !word_valid_o); // R8
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid_o |-> ($stable(word_o) && $stable(word_cmd_o))); // R8

endmodule

bind mwd_decoder mwd_decoder_chk #(
   .OSR         (OSR),
   .DATA_W      (DATA_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_pos_i     (rx_pos_i),
   .rx_neg_i     (rx_neg_i),
   .word_o       (word_o),
   .word_valid_o (word_valid_o),
   .word_cmd_o   (word_cmd_o),
   .par_err_o    (par_err_o),
   .trans_err_o  (trans_err_o),
   .sync_err_o   (sync_err_o)
);

// File: tb/mwd_decoder_test.sv
`timescale 1ns/1ps
module mwd_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_pos = 1'b0;
   logic        rx_neg = 1'b0;
   logic [19:0] word;
   logic        valid, cmd, perr, terr, serr;

   mwd_decoder uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_pos_i     (rx_pos),
      .rx_neg_i     (rx_neg),
      .word_o       (word),
      .word_valid_o (valid),
      .word_cmd_o   (cmd),
      .par_err_o    (perr),
      .trans_err_o  (terr),
      .sync_err_o   (serr)
   );

   always #2.5 clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   int ev_valid = 0, ev_trans = 0, ev_sync = 0, ev_perr = 0;
   logic [19:0] seen_word = '0;
   logic        seen_cmd = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (valid) begin
            ev_valid++;
            seen_word = word;
            seen_cmd  = cmd;
            if (perr) ev_perr++;
         end
         if (terr) ev_trans++;
         if (serr) ev_sync++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive_level(input logic lv);
      @(negedge clk);
      rx_pos = lv;
      rx_neg = ~lv;
   endtask

   task automatic go_idle(input int n);
      repeat (n) begin
         @(negedge clk);
         rx_pos = 1'b0;
         rx_neg = 1'b0;
      end
   endtask

   // Sample-exact waveform: 48-sample sync whose level change sits at
   // 24+shift, then 17 cells of 16 samples; cell 'flat' has no mid transition.
   task automatic send(input logic is_cmd, input logic [15:0] d, input logic p,
                       input int shift, input int flat);
      for (int s = 0; s < 48; s++) begin
         drive_level((s < 24 + shift) ? is_cmd : ~is_cmd);
      end
      for (int b = 0; b < 17; b++) begin
         logic v;
         v = (b < 16) ? d[15-b] : p;
         for (int ph = 0; ph < 16; ph++) begin
            drive_level((ph < 8 || b == flat) ? v : ~v);
         end
      end
   endtask

   task automatic word_case(input string req, input logic is_cmd, input logic [15:0] d,
                            input logic p, input int shift, input int flat);
      int v0, t0, s0, p0;
      v0 = ev_valid; t0 = ev_trans; s0 = ev_sync; p0 = ev_perr;
      send(is_cmd, d, p, shift, flat);
      go_idle(40);
      if (shift > 2 || shift < -2) begin
         check({req, " sync error pulse"}, ev_sync - s0, 1);
         check({req, " no word after bad sync"}, ev_valid - v0, 0);
      end else if (flat >= 0) begin
         check({req, " transition error pulse"}, ev_trans - t0, 1);
         check({req, " no word after bad bit"}, ev_valid - v0, 0);
      end else begin
         check({req, " one strobe"}, ev_valid - v0, 1);
         check({req, " no error pulse"}, (ev_trans - t0) + (ev_sync - s0), 0);
         check({req, " word value"}, seen_word,
               {is_cmd ? 3'b011 : 3'b100, d, p});
         check({req, " kind flag"}, seen_cmd, is_cmd);
         check({req, " parity verdict"}, ev_perr - p0, (^{d, p}) ? 0 : 1);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] d;
      repeat (5) @(negedge clk);
      // R1: reset state
      check("R1 reset flags", {valid, cmd, perr, terr, serr}, 0);
      check("R1 reset word", word, 0);
      rst_n = 1'b1;
      go_idle(100);
      check("R1 idle line silent", ev_valid + ev_trans + ev_sync, 0);

      // R5: one-hot data sweep, both word kinds
      for (int i = 0; i < 16; i++) begin
         for (int t = 0; t < 2; t++) begin
            d = 16'h0001 << i;
            word_case("R5", t[0], d, ~^d, 0, -1);
         end
      end
      word_case("R2", 1'b1, 16'h0000, 1'b1, 0, -1);
      word_case("R3", 1'b0, 16'hFFFF, 1'b1, 0, -1);

      // R2 / R3: arithmetic data sweep, alternating kinds
      for (int k = 0; k < 24; k++) begin
         d = 16'(k * 16'h2B37) ^ 16'(k << 9);
         if (k[0]) word_case("R2", 1'b1, d, ~^d, 0, -1);
         else      word_case("R3", 1'b0, d, ~^d, 0, -1);
      end

      // R7: wrong parity still delivers the word with the flag
      for (int k = 0; k < 8; k++) begin
         d = 16'h0F0F + 16'(k * 16'h1111);
         word_case("R7", k[1], d, ^d, 0, -1);
      end

      // R4: sync edge shifted across and beyond the tolerance
      for (int sh = -3; sh <= 3; sh++) begin
         for (int t = 0; t < 2; t++) begin
            word_case("R4", t[0], 16'hA5C3, ~^16'hA5C3, sh, -1);
         end
      end

      // R6: flat cell at every bit position including parity
      for (int f = 0; f < 17; f++) begin
         word_case("R6", f[0], 16'h3C5A, ~^16'h3C5A, 0, f);
      end

      // R8: word holds across idle and across a failed word
      word_case("R8", 1'b1, 16'h9E21, ~^16'h9E21, 0, -1);
      go_idle(50);
      check("R8 word held over idle", word, {3'b011, 16'h9E21, ~^16'h9E21});
      word_case("R8", 1'b0, 16'h1234, ~^16'h1234, 0, 5);
      check("R8 word held over failed word", word, {3'b011, 16'h9E21, ~^16'h9E21});
      check("R8 kind held over failed word", cmd, 1'b1);

      // R9: back-to-back words without idle gap: only the first is taken
      begin
         int v0;
         v0 = ev_valid;
         send(1'b0, 16'h5A5A, ~^16'h5A5A, 0, -1);
         send(1'b1, 16'hC0DE, ~^16'hC0DE, 0, -1);
         go_idle(40);
         check("R9 one strobe for two abutting words", ev_valid - v0, 1);
         check("R9 first word kept", word, {3'b100, 16'h5A5A, ~^16'h5A5A});
      end
      word_case("R9", 1'b1, 16'hC0DE, ~^16'hC0DE, 0, -1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule